// File: doc/BRIEF.md
# Four-Lane Single-Precision Min/Max Unit with Selectable NaN Conventions

This block takes two 128-bit vectors, each holding four single-precision values, and returns either the smaller or the larger value of each lane pair. A 4-bit mode input picks one of several conventions for NaN inputs and for pairs of zeros. The conventions are IEEE minNum/maxNum, Java, C macro, C++ and Fortran. The top mode bit selects a magnitude variant. A per-lane invalid flag reports signaling NaNs and the conventions that always flag a NaN.

The result and the flags are registered and appear one clock after the operands are presented. A single-lane input restricts the work to lane 0. In that case the other lanes return zero and raise no flag. The block is meant for the execution stage of a vector floating-point pipeline. Trap handling and other precisions are left to the surrounding logic.

Top module: `fpmm_unit`

## Requirements
- R1: Outputs are registered. Operands sampled at a rising clock edge produce their result and flags after that edge. An active-low asynchronous reset clears the result and the flags to zero.
- R2: Mode bits [2:0] select the convention: 0 IEEE, 1 Java, 2 C macro, 3 C++, 4 Fortran. The values 5 to 7 behave as IEEE. Mode bit 3 selects the magnitude variant. In the non-IEEE conventions, this variant clears both sign bits before anything else. Lane i occupies bits 32i+31 down to 32i. A set select input requests maximum, and a clear one requests minimum.
- R3: In a non-IEEE convention with no NaN and not both operands zero, the lane returns the numerically smaller (minimum) or larger (maximum) operand, after any sign clearing.
- R4: A value is a NaN when its exponent bits [30:23] are all ones and its fraction bits [22:0] are not all zero. A NaN is signaling when bit 22 is zero, and quieting sets bit 22. In a non-IEEE convention, a signaling NaN in either operand sets that lane's invalid flag. The flag is never set for a lane whose operands are both non-NaN.
- R5: Java, with a NaN present: if the first operand is signaling, the result is that operand quieted. Otherwise, if the second operand is signaling, the result is that operand quieted. Otherwise the result is whichever operand is a NaN, with the first operand taking precedence.
- R6: Fortran, with a NaN present: the result is the first operand when the second is a NaN, and the second operand otherwise. No quieting is applied.
- R7: With a NaN present, C macro returns the second operand and C++ returns the first, both unmodified, and both set the invalid flag.
- R8: When both operands are zeros under Java or Fortran, minimum returns the first operand if it is negative and the second otherwise. Maximum returns the second operand if the first is negative and the first otherwise.
- R9: When both operands are zeros, C macro returns the second operand and C++ returns the first, for both minimum and maximum.
- R10: In IEEE mode, two non-NaN operands are ordered with negative zero below positive zero.
- R11: In IEEE mode, a quiet NaN paired with a number yields the number. A signaling NaN yields that NaN quieted and sets invalid. Two NaNs yield the first operand quieted, with invalid set if either is signaling.
- R12: In the IEEE magnitude variant, operands are ordered by absolute value but returned with their own signs. Equal magnitudes fall back to the R10 ordering.
- R13: With single-lane set, lane 0 is processed normally while lanes 1 to 3 return zero and clear invalid flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_a | input | 128 | First operand vector, four lanes |
| vec_b | input | 128 | Second operand vector, four lanes |
| sel_max | input | 1 | 1 selects maximum, 0 selects minimum |
| mode | input | 4 | Convention in bits [2:0], magnitude variant in bit 3 |
| single_lane | input | 1 | Process lane 0 only |
| res_out | output | 128 | Registered result vector |
| inv_out | output | 4 | Registered per-lane invalid flags |

## Verification
Ordinary number pairs with mixed signs are run in every convention. They show that the plain ordering is shared and that the sign clearing of the magnitude variant changes the returned value only outside IEEE mode. Quiet and signaling NaNs are placed in each operand position in turn. These cases separate the Java precedence chain, the Fortran second-operand test and the fixed picks of C macro and C++, and they show whether quieting and the invalid flag follow the signaling bit. Zero pairs in both sign orders expose the asymmetric minimum and maximum rules. A NaN in one lane alone, and the single-lane mode, show that lanes stay independent.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    // Convention codes carried in mode[2:0]
    localparam logic [2:0] KIND_IEEE  = 3'd0;
    localparam logic [2:0] KIND_JAVA  = 3'd1;
    localparam logic [2:0] KIND_CMAC  = 3'd2;
    localparam logic [2:0] KIND_CPP   = 3'd3;
    localparam logic [2:0] KIND_FORT  = 3'd4;

    // Classification of one operand
    typedef struct packed {
        logic nan;
        logic snan;
        logic zero;
        logic neg;
    } fcls_t;

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
    import fpmm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] raw_val,
    input  logic                  clear_sign,
    output logic [EXP_W+FRAC_W:0] opnd,
    output fcls_t                 cls
);
    localparam int W = EXP_W + FRAC_W + 1;

    logic exp_ones;
    logic frac_nz;

    always_comb begin
        opnd     = clear_sign ? {1'b0, raw_val[W-2:0]} : raw_val;
        exp_ones = &opnd[W-2:FRAC_W];
        frac_nz  = |opnd[FRAC_W-1:0];
        cls.nan  = exp_ones & frac_nz;
        cls.snan = exp_ones & frac_nz & ~opnd[FRAC_W-1];
        cls.zero = ~|opnd[W-2:0];
        cls.neg  = opnd[W-1];
    end
endmodule

// File: rtl/fpmm_lane.sv
module fpmm_lane
    import fpmm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic [2:0]            kind,
    input  logic                  mag,
    input  logic                  sel_max,
    output logic [EXP_W+FRAC_W:0] lane_res,
    output logic                  lane_inv
);
    localparam int W    = EXP_W + FRAC_W + 1;
    localparam int QBIT = FRAC_W - 1;
    localparam logic [W-1:0] QMASK = W'(1) << QBIT;

    logic          is_ieee;
    logic          clear_sign;
    logic [W-1:0]  ca, cb;
    fcls_t         a_cls, b_cls;
    logic          any_nan;
    logic          signed_lt;
    logic [W-1:0]  signed_pick;
    logic          mag_lt, mag_eq;

    assign is_ieee    = (kind == KIND_IEEE) || (kind > KIND_FORT);
    assign clear_sign = mag & ~is_ieee;

    fpmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
        .raw_val(op_a), .clear_sign(clear_sign), .opnd(ca), .cls(a_cls)
    );
    fpmm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
        .raw_val(op_b), .clear_sign(clear_sign), .opnd(cb), .cls(b_cls)
    );

    // Ordering of two non-NaN operands, negative zero below positive zero
    always_comb begin
        if (ca[W-1] != cb[W-1]) begin
            signed_lt = ca[W-1];
        end else if (ca[W-1]) begin
            signed_lt = ca[W-2:0] > cb[W-2:0];
        end else begin
            signed_lt = ca[W-2:0] < cb[W-2:0];
        end
        signed_pick = (signed_lt ^ sel_max) ? ca : cb;
        mag_lt      = ca[W-2:0] < cb[W-2:0];
        mag_eq      = ca[W-2:0] == cb[W-2:0];
        any_nan     = a_cls.nan | b_cls.nan;
    end

    always_comb begin
        lane_res = signed_pick;
        lane_inv = 1'b0;
        if (is_ieee) begin
            if (a_cls.nan && b_cls.nan) begin
                lane_res = ca | QMASK;
                lane_inv = a_cls.snan | b_cls.snan;
            end else if (a_cls.nan) begin
                lane_res = a_cls.snan ? (ca | QMASK) : cb;
                lane_inv = a_cls.snan;
            end else if (b_cls.nan) begin
                lane_res = b_cls.snan ? (cb | QMASK) : ca;
                lane_inv = b_cls.snan;
            end else if (mag && !mag_eq) begin
                lane_res = (mag_lt ^ sel_max) ? ca : cb;
            end
        end else if (any_nan) begin
            lane_inv = a_cls.snan | b_cls.snan;
            case (kind)
                KIND_JAVA: begin
                    if (a_cls.snan)      lane_res = ca | QMASK;
                    else if (b_cls.snan) lane_res = cb | QMASK;
                    else if (a_cls.nan)  lane_res = ca;
                    else                 lane_res = cb;
                end
                KIND_FORT: lane_res = b_cls.nan ? ca : cb;
                KIND_CMAC: begin
                    lane_res = cb;
                    lane_inv = 1'b1;
                end
                default: begin
                    lane_res = ca;
                    lane_inv = 1'b1;
                end
            endcase
        end else if (a_cls.zero && b_cls.zero) begin
            case (kind)
                KIND_CMAC: lane_res = cb;
                KIND_CPP:  lane_res = ca;
                default:   lane_res = (a_cls.neg ^ sel_max) ? ca : cb;
            endcase
        end
    end
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
    import fpmm_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES*(EXP_W+FRAC_W+1)-1:0] vec_a,
    input  logic [LANES*(EXP_W+FRAC_W+1)-1:0] vec_b,
    input  logic                          sel_max,
    input  logic [3:0]                    mode,
    input  logic                          single_lane,
    output logic [LANES*(EXP_W+FRAC_W+1)-1:0] res_out,
    output logic [LANES-1:0]              inv_out
);
    localparam int W  = EXP_W + FRAC_W + 1;
    localparam int VW = LANES * W;

    typedef struct packed {
        logic [VW-1:0]    res;
        logic [LANES-1:0] inv;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0]     lane_res [LANES];
    logic [LANES-1:0] lane_inv;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        fpmm_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lane (
            .op_a    (vec_a[i*W +: W]),
            .op_b    (vec_b[i*W +: W]),
            .kind    (mode[2:0]),
            .mag     (mode[3]),
            .sel_max (sel_max),
            .lane_res(lane_res[i]),
            .lane_inv(lane_inv[i])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < LANES; i++) begin
            if (single_lane && i != 0) begin
                state_d.res[i*W +: W] = '0;
                state_d.inv[i]        = 1'b0;
            end else begin
                state_d.res[i*W +: W] = lane_res[i];
                state_d.inv[i]        = lane_inv[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_out = state_q.res;
    assign inv_out = state_q.inv;

    // Lane-0 operand classes observed straight from the ports
    logic a0_nan, b0_nan, a0_snan;
    assign a0_nan  = (&vec_a[W-2:FRAC_W]) & (|vec_a[FRAC_W-1:0]);
    assign b0_nan  = (&vec_b[W-2:FRAC_W]) & (|vec_b[FRAC_W-1:0]);
    assign a0_snan = a0_nan & ~vec_a[FRAC_W-1];

    AST_SINGLE_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        single_lane |=> (res_out[VW-1:W] == '0) && (inv_out[LANES-1:1] == '0)); // R13

    AST_INV_NEEDS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        (!a0_nan && !b0_nan) |=> !inv_out[0]); // R4

    AST_CMACRO_NAN_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'd2 && (a0_nan || b0_nan))
        |=> (res_out[W-1:0] == $past(vec_b[W-1:0])) && inv_out[0]); // R7

    AST_JAVA_SNAN_QUIETED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[2:0] == 3'd1 && a0_snan)
        |=> (&res_out[W-2:FRAC_W]) && res_out[FRAC_W-1] && inv_out[0]); // R5
endmodule

// File: tb/fpmm_unit_test.sv
`timescale 1ns/1ps
module fpmm_unit_test;
    localparam int W  = 32;
    localparam int VW = 128;
    localparam int NVEC = 34;

    // entry: mode[105:102] max[101] a[100:69] b[68:37] exp[36:5] inv[4] req[3:0]
    localparam logic [105:0] VEC [NVEC] = '{
        {4'd0, 1'b0, 32'h3F800000, 32'h40000000, 32'h3F800000, 1'b0, 4'd10}, // R10
        {4'd0, 1'b1, 32'hBF800000, 32'h3F800000, 32'h3F800000, 1'b0, 4'd10}, // R10
        {4'd0, 1'b0, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0, 4'd10}, // R10
        {4'd0, 1'b1, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0, 4'd10}, // R10
        {4'd0, 1'b0, 32'h7FC00000, 32'h40000000, 32'h40000000, 1'b0, 4'd11}, // R11
        {4'd0, 1'b1, 32'h3F800000, 32'h7FC00000, 32'h3F800000, 1'b0, 4'd11}, // R11
        {4'd0, 1'b0, 32'h7F800001, 32'h3F800000, 32'h7FC00001, 1'b1, 4'd11}, // R11
        {4'd0, 1'b0, 32'h7FC00055, 32'h7F800001, 32'h7FC00055, 1'b1, 4'd11}, // R11
        {4'd8, 1'b0, 32'hC0400000, 32'h3F800000, 32'h3F800000, 1'b0, 4'd12}, // R12
        {4'd8, 1'b1, 32'hC0400000, 32'h3F800000, 32'hC0400000, 1'b0, 4'd12}, // R12
        {4'd8, 1'b0, 32'h3F800000, 32'hBF800000, 32'hBF800000, 1'b0, 4'd12}, // R12
        {4'd1, 1'b0, 32'hC0400000, 32'h3F800000, 32'hC0400000, 1'b0, 4'd3},  // R3
        {4'd9, 1'b0, 32'hC0400000, 32'h3F800000, 32'h3F800000, 1'b0, 4'd3},  // R3
        {4'd9, 1'b1, 32'hC0400000, 32'h3F800000, 32'h40400000, 1'b0, 4'd3},  // R3
        {4'd2, 1'b1, 32'h3F800000, 32'h40000000, 32'h40000000, 1'b0, 4'd3},  // R3
        {4'd1, 1'b0, 32'h7F800001, 32'hFF800002, 32'h7FC00001, 1'b1, 4'd5},  // R5
        {4'd1, 1'b0, 32'h7FC00000, 32'hFF800002, 32'hFFC00002, 1'b1, 4'd5},  // R5
        {4'd1, 1'b1, 32'h7FC00000, 32'h7FC00055, 32'h7FC00000, 1'b0, 4'd5},  // R5
        {4'd1, 1'b1, 32'h3F800000, 32'h7FC00055, 32'h7FC00055, 1'b0, 4'd5},  // R5
        {4'd9, 1'b0, 32'hFF800002, 32'h3F800000, 32'h7FC00002, 1'b1, 4'd2},  // R2
        {4'd4, 1'b0, 32'h7FC00000, 32'h3F800000, 32'h3F800000, 1'b0, 4'd6},  // R6
        {4'd4, 1'b1, 32'h3F800000, 32'h7FC00055, 32'h3F800000, 1'b0, 4'd6},  // R6
        {4'd4, 1'b0, 32'h7F800001, 32'h40000000, 32'h40000000, 1'b1, 4'd4},  // R4
        {4'd2, 1'b0, 32'h3F800000, 32'h7FC00000, 32'h7FC00000, 1'b1, 4'd7},  // R7
        {4'd3, 1'b1, 32'h7FC00055, 32'h3F800000, 32'h7FC00055, 1'b1, 4'd7},  // R7
        {4'd2, 1'b1, 32'h7F800001, 32'h3F800000, 32'h3F800000, 1'b1, 4'd7},  // R7
        {4'd1, 1'b0, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0, 4'd8},  // R8
        {4'd1, 1'b0, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0, 4'd8},  // R8
        {4'd4, 1'b1, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0, 4'd8},  // R8
        {4'd1, 1'b1, 32'h00000000, 32'h80000000, 32'h00000000, 1'b0, 4'd8},  // R8
        {4'd2, 1'b0, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0, 4'd9},  // R9
        {4'd3, 1'b1, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0, 4'd9},  // R9
        {4'd5, 1'b0, 32'h7FC00000, 32'h3F800000, 32'h3F800000, 1'b0, 4'd2},  // R2
        {4'd11, 1'b0, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0, 4'd2}  // R2
    };

    logic           clk;
    logic           rst_n;
    logic [VW-1:0]  vec_a, vec_b;
    logic           sel_max;
    logic [3:0]     mode;
    logic           single_lane;
    logic [VW-1:0]  res_out;
    logic [3:0]     inv_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    fpmm_unit uut (
        .clk(clk), .rst_n(rst_n), .vec_a(vec_a), .vec_b(vec_b),
        .sel_max(sel_max), .mode(mode), .single_lane(single_lane),
        .res_out(res_out), .inv_out(inv_out)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [VW+3:0] got, input logic [VW+3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%h inv=%b, expected res=%h inv=%b",
                     req, got[VW+3:4], got[3:0], exp[VW+3:4], exp[3:0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got no completion, expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] rest;
        rst_n = 1'b0;
        vec_a = {4{32'h3F800000}};
        vec_b = {4{32'h40000000}};
        sel_max = 1'b0;
        mode = 4'd0;
        single_lane = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", {res_out, inv_out}, '0);
        rst_n = 1'b1;

        // R1: latency of one edge
        @(negedge clk);
        vec_a = {4{32'h7F800001}};
        vec_b = {4{32'h3F800000}};
        mode = 4'd2;
        #1;
        check("R1 hold", {res_out, inv_out}, {{4{32'h3F800000}}, 4'b0000});
        @(negedge clk);
        check("R1 update", {res_out, inv_out}, {{4{32'h3F800000}}, 4'b1111});

        // table walk: lane 0 from the table, lanes 1..3 fixed 1.0 vs 2.0
        for (int i = 0; i < NVEC; i++) begin
            logic [105:0] e;
            e = VEC[i];
            @(negedge clk);
            mode    = e[105:102];
            sel_max = e[101];
            vec_a   = {{3{32'h3F800000}}, e[100:69]};
            vec_b   = {{3{32'h40000000}}, e[68:37]};
            rest    = e[101] ? 32'h40000000 : 32'h3F800000;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", e[3:0], i), {res_out, inv_out},
                  {rest, rest, rest, e[36:5], 3'b000, e[4]});
        end

        // R13: single-lane leaves upper lanes zero even with NaNs there
        @(negedge clk);
        mode = 4'd2; sel_max = 1'b0; single_lane = 1'b1;
        vec_a = {4{32'h7FC00000}};
        vec_b = {4{32'h3F800000}};
        @(negedge clk);
        check("R13 single lane", {res_out, inv_out},
              {32'h0, 32'h0, 32'h0, 32'h3F800000, 4'b0001});

        // R4/R7: a NaN in lane 2 alone flags lane 2 only
        @(negedge clk);
        single_lane = 1'b0;
        vec_a = {32'h3F800000, 32'h7FC00000, 32'h3F800000, 32'h3F800000};
        vec_b = {4{32'h40000000}};
        @(negedge clk);
        check("R7 lane independence", {res_out, inv_out},
              {32'h3F800000, 32'h40000000, 32'h3F800000, 32'h3F800000, 4'b0100});

        // R4: no NaN anywhere in C++ mode raises nothing
        @(negedge clk);
        mode = 4'd3; sel_max = 1'b1;
        vec_a = {4{32'hBF800000}};
        @(negedge clk);
        check("R4 no NaN no flag", {res_out, inv_out}, {{4{32'h40000000}}, 4'b0000});

        // R1: reset in mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", {res_out, inv_out}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule